// File: doc/BRIEF.md
# Rule Bit-Vector Combiner

This block sits behind the lookup engines of a header classifier. It produces the final set of rules that a packet matches. Three vectors arrive. One is a compressed header-match vector with one bit per shared address/protocol entry. The other two are rule-indexed bit vectors, one for the source port and one for the destination port. Each may arrive in its own cycle, each with its own valid strobe. Several rules may share the same address and protocol specification and so share one entry. The entry vector is therefore first expanded into rule bits through a table that holds one rule mask per entry. The expanded vector is then ANDed with both port vectors, because a rule hits only when every field hits.

The mask table can be rewritten at any time, one entry per cycle, while lookups continue. The result reports every matching rule. It also gives the index of the lowest-numbered hit and a flag for the case where nothing hit. All three outputs are registered and qualified by a one-cycle valid pulse.

Top module: `rule_vec_combiner`

## Requirements
- R1: After reset, matchValid, matchVec and noMatch are all 0, and every mask in the table is zero.
- R2: matchValid pulses high for exactly one cycle, on the cycle after the one in which the last of the three input valids has arrived. The three valids may come together or spread over several cycles, and matchValid stays low until all three have been seen.
- R3: The expanded vector is the bitwise OR of the masks of all entries whose bit is set in entryVec. Bit i of entryVec selects mask i.
- R4: matchVec equals the expanded vector ANDed with srcVec and with dstVec. Bit r of each rule vector stands for rule r.
- R5: When several rules survive the AND, all of their bits are set in matchVec together.
- R6: firstRule is the index of the lowest set bit of matchVec, and is 0 when matchVec is zero.
- R7: noMatch is 1 exactly when the reported matchVec is all zeros.
- R8: When cfgWrEn is high, cfgWrMask is written to entry cfgWrAddr at the clock edge. A combine that completes in the same cycle still uses the old mask, and later combines use the new one.
- R9: If a vector's valid repeats before all three have been collected, the newer value replaces the held one.
- R10: Between valid pulses, matchVec, firstRule and noMatch keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Mask table write strobe |
| cfgWrAddr | input | ADDR_W | Entry index to rewrite |
| cfgWrMask | input | NUM_RULES | New rule mask for that entry |
| entryValid | input | 1 | entryVec is valid this cycle |
| entryVec | input | NUM_ENTRIES | Compressed header-match vector |
| srcValid | input | 1 | srcVec is valid this cycle |
| srcVec | input | NUM_RULES | Source-port rule vector |
| dstValid | input | 1 | dstVec is valid this cycle |
| dstVec | input | NUM_RULES | Destination-port rule vector |
| matchValid | output | 1 | One-cycle pulse qualifying the result |
| matchVec | output | NUM_RULES | All matching rules |
| firstRule | output | IDX_W | Lowest matching rule index |
| noMatch | output | 1 | Result vector is empty |

## Verification
The bench builds the block with 6 entries and 12 rules. These widths are not powers of two, so the top index of the priority encoder and of the mask address is reachable while some address codes stay unused. With 12 rules, random port vectors regularly leave several survivors and also regularly leave none. That covers multiple hits, the lowest-index choice and the empty result. Six entries let a single write-then-combine race and a full table rewrite each be tried in a few cycles.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
  typedef struct packed {
    logic takeEntry;
    logic takeSrc;
    logic takeDst;
    logic fire;
  } rvcStrobe_t;
endpackage

// File: rtl/rvc_ctrl.sv
module rvc_ctrl
  import rvc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       entryValid,
  input  logic       srcValid,
  input  logic       dstValid,
  output rvcStrobe_t strobe
);
  logic hasEntry, hasSrc, hasDst;
  logic allReady;

  assign allReady = (hasEntry | entryValid) & (hasSrc | srcValid) & (hasDst | dstValid);

  always_comb begin
    strobe.takeEntry = entryValid;
    strobe.takeSrc   = srcValid;
    strobe.takeDst   = dstValid;
    strobe.fire      = allReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hasEntry <= 1'b0;
      hasSrc   <= 1'b0;
      hasDst   <= 1'b0;
    end else if (allReady) begin
      hasEntry <= 1'b0;
      hasSrc   <= 1'b0;
      hasDst   <= 1'b0;
    end else begin
      if (entryValid) hasEntry <= 1'b1;
      if (srcValid)   hasSrc   <= 1'b1;
      if (dstValid)   hasDst   <= 1'b1;
    end
  end

  // R2: a completed collection leaves no stale flags behind
  assert_flags_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    allReady |=> !(hasEntry || hasSrc || hasDst));

  // R9: a lone arrival is remembered until the set is complete
  assert_entry_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (entryValid && !allReady) |=> hasEntry);
endmodule

// File: rtl/rvc_datapath.sv
module rvc_datapath
  import rvc_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_RULES   = 16,
  parameter int ADDR_W      = 3,
  parameter int IDX_W       = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  rvcStrobe_t             strobe,
  input  logic                   cfgWrEn,
  input  logic [ADDR_W-1:0]      cfgWrAddr,
  input  logic [NUM_RULES-1:0]   cfgWrMask,
  input  logic [NUM_ENTRIES-1:0] entryVec,
  input  logic [NUM_RULES-1:0]   srcVec,
  input  logic [NUM_RULES-1:0]   dstVec,
  output logic                   matchValid,
  output logic [NUM_RULES-1:0]   matchVec,
  output logic [IDX_W-1:0]       firstRule,
  output logic                   noMatch
);
  logic [NUM_RULES-1:0]   maskTab [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] heldEntry, effEntry;
  logic [NUM_RULES-1:0]   heldSrc, heldDst, effSrc, effDst;
  logic [NUM_RULES-1:0]   expanded, combined;
  logic [IDX_W-1:0]       lowIdx;

  // Mask table: one row per compressed entry
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gMaskRow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) maskTab[g] <= '0;
      else if (cfgWrEn && (cfgWrAddr == ADDR_W'(g))) maskTab[g] <= cfgWrMask;
    end
  end

  // Holding registers for vectors that arrive early
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldEntry <= '0;
      heldSrc   <= '0;
      heldDst   <= '0;
    end else begin
      if (strobe.takeEntry) heldEntry <= entryVec;
      if (strobe.takeSrc)   heldSrc   <= srcVec;
      if (strobe.takeDst)   heldDst   <= dstVec;
    end
  end

  assign effEntry = strobe.takeEntry ? entryVec : heldEntry;
  assign effSrc   = strobe.takeSrc   ? srcVec   : heldSrc;
  assign effDst   = strobe.takeDst   ? dstVec   : heldDst;

  // Decompression: OR of selected masks
  always_comb begin
    expanded = '0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (effEntry[i]) expanded = expanded | maskTab[i];
  end

  assign combined = expanded & effSrc & effDst;

  // Lowest-index priority encoder
  always_comb begin
    lowIdx = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--)
      if (combined[i]) lowIdx = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchValid <= 1'b0;
      matchVec   <= '0;
      firstRule  <= '0;
      noMatch    <= 1'b0;
    end else begin
      matchValid <= strobe.fire;
      if (strobe.fire) begin
        matchVec  <= combined;
        firstRule <= lowIdx;
        noMatch   <= ~|combined;
      end
    end
  end

  // R7: empty flag agrees with the reported vector
  assert_empty_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    matchValid |-> (noMatch == (matchVec == '0)));

  // R6: the reported index points at a set bit with none below it
  assert_low_index_R6: assert property (@(posedge clk) disable iff (!rstN)
    (matchValid && !noMatch) |-> (matchVec[firstRule] &&
      ((matchVec & ((NUM_RULES'(1) << firstRule) - NUM_RULES'(1))) == '0)));

  // R4: no reported rule lies outside the port vectors used
  assert_port_subset_R4: assert property (@(posedge clk) disable iff (!rstN)
    matchValid |-> ((matchVec & ~($past(effSrc) & $past(effDst))) == '0));

  // R10: result is frozen while no combine completes
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.fire |=> ($stable(matchVec) && $stable(firstRule) && $stable(noMatch)));
endmodule

// File: rtl/rule_vec_combiner.sv
module rule_vec_combiner
  import rvc_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_RULES   = 16,
  localparam int ADDR_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int IDX_W  = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWrEn,
  input  logic [ADDR_W-1:0]      cfgWrAddr,
  input  logic [NUM_RULES-1:0]   cfgWrMask,
  input  logic                   entryValid,
  input  logic [NUM_ENTRIES-1:0] entryVec,
  input  logic                   srcValid,
  input  logic [NUM_RULES-1:0]   srcVec,
  input  logic                   dstValid,
  input  logic [NUM_RULES-1:0]   dstVec,
  output logic                   matchValid,
  output logic [NUM_RULES-1:0]   matchVec,
  output logic [IDX_W-1:0]       firstRule,
  output logic                   noMatch
);
  rvcStrobe_t strobe;

  rvc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .entryValid (entryValid),
    .srcValid   (srcValid),
    .dstValid   (dstValid),
    .strobe     (strobe)
  );

  rvc_datapath #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .NUM_RULES   (NUM_RULES),
    .ADDR_W      (ADDR_W),
    .IDX_W       (IDX_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgWrEn    (cfgWrEn),
    .cfgWrAddr  (cfgWrAddr),
    .cfgWrMask  (cfgWrMask),
    .entryVec   (entryVec),
    .srcVec     (srcVec),
    .dstVec     (dstVec),
    .matchValid (matchValid),
    .matchVec   (matchVec),
    .firstRule  (firstRule),
    .noMatch    (noMatch)
  );
endmodule

// File: tb/rule_vec_combiner_tb.sv
module rule_vec_combiner_tb;
  localparam int NE = 6;
  localparam int NR = 12;
  localparam int AW = 3;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [AW-1:0] cfgWrAddr = '0;
  logic [NR-1:0] cfgWrMask = '0;
  logic          entryValid = 1'b0, srcValid = 1'b0, dstValid = 1'b0;
  logic [NE-1:0] entryVec = '0;
  logic [NR-1:0] srcVec = '0, dstVec = '0;
  logic          matchValid, noMatch;
  logic [NR-1:0] matchVec;
  logic [IW-1:0] firstRule;

  int total = 0;
  int bad = 0;
  logic [NR-1:0] shadow [NE];

  always #2 clk = ~clk;

  rule_vec_combiner #(.NUM_ENTRIES(NE), .NUM_RULES(NR)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr),
    .cfgWrMask(cfgWrMask), .entryValid(entryValid), .entryVec(entryVec),
    .srcValid(srcValid), .srcVec(srcVec), .dstValid(dstValid), .dstVec(dstVec),
    .matchValid(matchValid), .matchVec(matchVec), .firstRule(firstRule),
    .noMatch(noMatch)
  );

  function automatic logic [NR-1:0] expect_vec(logic [NE-1:0] e, logic [NR-1:0] s, logic [NR-1:0] d);
    logic [NR-1:0] x = '0;
    for (int i = 0; i < NE; i++) if (e[i]) x |= shadow[i];
    return x & s & d;
  endfunction

  function automatic logic [IW-1:0] expect_low(logic [NR-1:0] v);
    for (int i = 0; i < NR; i++) if (v[i]) return IW'(i);
    return '0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_mask(int a, logic [NR-1:0] m);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrAddr = AW'(a); cfgWrMask = m;
    @(negedge clk);
    cfgWrEn = 1'b0;
    shadow[a] = m;
  endtask

  // all three in one cycle; checks result on the next sample point
  task automatic combine_check(string req, logic [NE-1:0] e, logic [NR-1:0] s, logic [NR-1:0] d);
    logic [NR-1:0] ev;
    ev = expect_vec(e, s, d);
    @(negedge clk);
    entryValid = 1'b1; srcValid = 1'b1; dstValid = 1'b1;
    entryVec = e; srcVec = s; dstVec = d;
    @(negedge clk);
    entryValid = 1'b0; srcValid = 1'b0; dstValid = 1'b0;
    check({req, " valid"}, 32'(matchValid), 1);
    check({req, " vec"}, 32'(matchVec), 32'(ev));
    check({req, " first"}, 32'(firstRule), 32'(expect_low(ev)));
    check({req, " empty"}, 32'(noMatch), 32'(ev == '0));
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NR-1:0] oldVec;
    logic [NR-1:0] ev;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < NE; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 valid", 32'(matchValid), 0);
    check("R1 vec", 32'(matchVec), 0);
    check("R1 empty", 32'(noMatch), 0);
    rstN = 1'b1;
    // R1: masks zero after reset -> nothing matches
    combine_check("R1 masks", '1, '1, '1);

    // six-rule example: entry0->rules 0,1; entry1->rule 2; entry2->rule 3; entry3->rules 4,5
    write_mask(0, NR'(12'h003));
    write_mask(1, NR'(12'h004));
    write_mask(2, NR'(12'h008));
    write_mask(3, NR'(12'h030));
    // R3 R4: entries 0,1,3 hit; src {2,4,5}; dst {1,5} -> rule 5 only
    combine_check("R4 example", NE'(6'b001011), NR'(12'h034), NR'(12'h022));
    // R5: multiple survivors
    combine_check("R5 multi", NE'(6'b001111), NR'(12'h03f), NR'(12'h03d));
    // R3: expansion alone (ports all ones)
    combine_check("R3 expand", NE'(6'b000110), '1, '1);
    // R7: entries hit but ports exclude
    combine_check("R7 empty", NE'(6'b001111), NR'(12'h0c0), '1);

    // R8: write and combine in the same cycle use the old mask
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrAddr = AW'(4); cfgWrMask = NR'(12'h800);
    entryValid = 1'b1; srcValid = 1'b1; dstValid = 1'b1;
    entryVec = NE'(6'b010000); srcVec = '1; dstVec = '1;
    @(negedge clk);
    cfgWrEn = 1'b0; entryValid = 1'b0; srcValid = 1'b0; dstValid = 1'b0;
    check("R8 old mask", 32'(matchVec), 0);
    shadow[4] = NR'(12'h800);
    combine_check("R8 new mask", NE'(6'b010000), '1, '1);
    check("R6 top index", 32'(firstRule), 11);

    // R2: staggered arrival
    @(negedge clk); entryValid = 1'b1; entryVec = NE'(6'b001000);
    @(negedge clk); entryValid = 1'b0; srcValid = 1'b1; srcVec = NR'(12'h030);
    check("R2 wait1", 32'(matchValid), 0);
    @(negedge clk); srcValid = 1'b0;
    check("R2 wait2", 32'(matchValid), 0);
    // R9: a newer entry vector replaces the held one
    entryValid = 1'b1; entryVec = NE'(6'b000001);
    @(negedge clk); entryValid = 1'b0; dstValid = 1'b1; dstVec = '1;
    check("R2 wait3", 32'(matchValid), 0);
    @(negedge clk); dstValid = 1'b0;
    check("R2 pulse", 32'(matchValid), 1);
    check("R9 replace", 32'(matchVec), 0);
    check("R9 empty", 32'(noMatch), 1);
    oldVec = matchVec;
    @(negedge clk);
    check("R2 single pulse", 32'(matchValid), 0);
    // R10: inputs change without valids; outputs hold
    entryVec = '1; srcVec = '1; dstVec = '1;
    repeat (3) @(negedge clk);
    check("R10 hold vec", 32'(matchVec), 32'(oldVec));
    check("R10 hold empty", 32'(noMatch), 1);

    // random mix
    for (int it = 0; it < 60; it++) begin
      if ($urandom_range(0, 2) == 0)
        write_mask(int'($urandom_range(0, NE - 1)), NR'($urandom));
      ev = NR'($urandom) | NR'($urandom);
      combine_check("R4 random", NE'($urandom), ev, NR'($urandom) | NR'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule